// File: doc/BRIEF.md
# Temperature Threshold Alarm

This block watches a stream of temperature samples and raises an alarm when a sample crosses a programmable limit. Each sample is a 16-bit two's-complement value with six fractional bits, so one LSB is 1/64 degree. The threshold uses the same format. A 2-bit rule selector picks the alarm condition. Code 0 means the sample is at or below the threshold. Code 1 means the sample is at or above it. Codes 2 and 3 are reserved and never count as a match. The comparison is signed, so a negative temperature is always below a positive limit.

Three small two-state machines hold the block's state. Each one has the states ST_IDLE and ST_HELD, and moves along two transitions:

- SET takes ST_IDLE to ST_HELD.
- CLEAR takes ST_HELD back to ST_IDLE, but only when no set request arrives in the same cycle.

The three machines are:

- **Live status.** A valid matching sample sets it. A valid sample that does not match clears it. It therefore shows the result of the most recent sample.
- **Alarm flag.** A valid matching sample sets it. Software clears it with a write-to-clear strobe. The flag stays clear until a later sample matches again.
- **Data-ready.** Every valid sample sets it, and its own clear strobe clears it.

The interrupt output is the alarm flag gated by the interrupt enable. Software typically handles the interrupt this way: it clears the flag, drops the enable, programs a new threshold, then re-enables.

Top module: `thermal_threshold_alarm`

## Requirements
- R1: After reset, cmp_live, alarm_flag, data_ready and alarm_irq are all 0.
- R2: With cmp_mode = 0, a valid sample with signed sample <= threshold sets cmp_live and alarm_flag; both are visible on the cycle after the strobe edge. A greater sample leaves the flag clear and cmp_live at 0.
- R3: With cmp_mode = 1, a valid sample with signed sample >= threshold sets cmp_live and alarm_flag on the following cycle. A smaller sample does not.
- R4: The comparison is two's-complement. For example, 0xFFC0 (-1 degree) is below 0x0040 (+1 degree), and 0x8000 is below 0x7FFF.
- R5: With cmp_mode = 2 or 3, a valid sample never sets alarm_flag, and cmp_live reads 0 after it.
- R6: cmp_live changes only on a valid sample. Changing the sample, threshold or mode without a strobe leaves it unchanged.
- R7: Once set, alarm_flag stays at 1 through later non-matching samples until alarm_clr is pulsed.
- R8: A pulse on alarm_clr with no matching sample in the same cycle clears alarm_flag on the next cycle. The flag stays 0 until a new matching sample arrives, even if the threshold is changed so that the held sample would now match.
- R9: A matching valid sample in the same cycle as alarm_clr leaves alarm_flag at 1.
- R10: alarm_irq equals alarm_flag AND alarm_ie, combinationally, in the same cycle that either input changes.
- R11: data_ready goes to 1 on the cycle after any valid sample. A ready_clr pulse clears it. A valid sample in the same cycle as ready_clr wins, and data_ready stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_vld | input | 1 | One-cycle strobe: sample_temp holds a new sample |
| sample_temp | input | 16 | Signed sample, 1/64 degree per LSB |
| thresh_temp | input | 16 | Signed threshold, same format |
| cmp_mode | input | 2 | 0: sample <= threshold, 1: sample >= threshold, 2/3: reserved |
| alarm_ie | input | 1 | Interrupt enable |
| alarm_clr | input | 1 | Write-to-clear strobe for the alarm flag |
| ready_clr | input | 1 | Clear strobe for data-ready |
| cmp_live | output | 1 | Comparison result of the latest valid sample |
| alarm_flag | output | 1 | Sticky alarm flag |
| data_ready | output | 1 | New sample has arrived |
| alarm_irq | output | 1 | Interrupt, alarm_flag gated by alarm_ie |

## Verification
The vector table hits each rule on both sides of the threshold and exactly at it. An unsigned comparator would be caught by the samples that straddle zero and by the full-scale extremes, because it would flag -1 degree as hotter than +1. Reserved rule codes are driven with operands that would match under either real rule, which exposes a design that decodes only one mode bit. Directed tests cover the remaining failure modes:
- A clear that wins over a simultaneous set would drop a real alarm.
- A flag that re-arms from a stale sample would stay set after a clear when the threshold changes.
- Live status that follows the sample pins without a strobe would change between samples.
- An interrupt that ignores, or registers, the enable would show the wrong value in the same cycle.

// File: rtl/thalarm_pkg.sv
package thalarm_pkg;

    typedef enum logic [1:0] {
        CMP_LE   = 2'd0,
        CMP_GE   = 2'd1,
        CMP_RSV2 = 2'd2,
        CMP_RSV3 = 2'd3
    } cmp_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HELD = 1'b1
    } hold_state_e;

endpackage

// File: rtl/thalarm_compare.sv
module thalarm_compare #(
    parameter int DATA_W = 16,
    parameter int MODE_W = 2
) (
    input  logic [DATA_W-1:0] sample_i,
    input  logic [DATA_W-1:0] thresh_i,
    input  logic [MODE_W-1:0] mode_i,
    output logic              hit_o
);
    import thalarm_pkg::*;

    logic signed [DATA_W-1:0] s_sample;
    logic signed [DATA_W-1:0] s_thresh;
    cmp_mode_e                rule;

    always_comb begin
        s_sample = $signed(sample_i);
        s_thresh = $signed(thresh_i);
        rule     = cmp_mode_e'(mode_i);
    end

    // Signed compare; reserved codes never match.
    always_comb begin
        unique case (rule)
            CMP_LE:  hit_o = (s_sample <= s_thresh);
            CMP_GE:  hit_o = (s_sample >= s_thresh);
            default: hit_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/thalarm_hold_fsm.sv
module thalarm_hold_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic held_o
);
    import thalarm_pkg::*;

    hold_state_e state_q;
    hold_state_e state_d;

    // Next-state logic: SET has priority over CLEAR.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (set_i) state_d = ST_HELD;
            ST_HELD: if (clr_i && !set_i) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_HELD: held_o = 1'b1;
            default: held_o = 1'b0;
        endcase
    end

    assert_hold_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (held_o && !clr_i) |=> held_o);

    assert_clear_takes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !held_o);

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> held_o);

endmodule

// File: rtl/thermal_threshold_alarm.sv
module thermal_threshold_alarm #(
    parameter int DATA_W = 16,
    parameter int MODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_vld,
    input  logic [DATA_W-1:0] sample_temp,
    input  logic [DATA_W-1:0] thresh_temp,
    input  logic [MODE_W-1:0] cmp_mode,
    input  logic              alarm_ie,
    input  logic              alarm_clr,
    input  logic              ready_clr,
    output logic              cmp_live,
    output logic              alarm_flag,
    output logic              data_ready,
    output logic              alarm_irq
);
    logic hit;
    logic live_set;
    logic live_clr;
    logic flag_set;

    thalarm_compare #(
        .DATA_W (DATA_W),
        .MODE_W (MODE_W)
    ) u_compare (
        .sample_i (sample_temp),
        .thresh_i (thresh_temp),
        .mode_i   (cmp_mode),
        .hit_o    (hit)
    );

    always_comb begin
        live_set = sample_vld && hit;
        live_clr = sample_vld && !hit;
        flag_set = sample_vld && hit;
    end

    thalarm_hold_fsm u_live (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (live_set),
        .clr_i  (live_clr),
        .held_o (cmp_live)
    );

    thalarm_hold_fsm u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (flag_set),
        .clr_i  (alarm_clr),
        .held_o (alarm_flag)
    );

    thalarm_hold_fsm u_ready (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (sample_vld),
        .clr_i  (ready_clr),
        .held_o (data_ready)
    );

    always_comb alarm_irq = alarm_flag && alarm_ie;

    assert_le_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_vld && cmp_mode == 2'd0 && $signed(sample_temp) <= $signed(thresh_temp))
        |=> (alarm_flag && cmp_live));

    assert_ge_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_vld && cmp_mode == 2'd1 && $signed(sample_temp) >= $signed(thresh_temp))
        |=> (alarm_flag && cmp_live));

    assert_reserved_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_vld && cmp_mode[1]) |=> !cmp_live);

    assert_live_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_vld |=> $stable(cmp_live));

    assert_irq_needs_ie_R10: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_irq |-> (alarm_ie && alarm_flag));

    assert_ready_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sample_vld |=> data_ready);

endmodule

// File: tb/thermal_threshold_alarm_tb.sv
`timescale 1ns/1ps
module thermal_threshold_alarm_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_vld = 1'b0;
    logic [15:0] sample_temp = '0;
    logic [15:0] thresh_temp = '0;
    logic [1:0]  cmp_mode = '0;
    logic        alarm_ie = 1'b0;
    logic        alarm_clr = 1'b0;
    logic        ready_clr = 1'b0;
    logic        cmp_live;
    logic        alarm_flag;
    logic        data_ready;
    logic        alarm_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    thermal_threshold_alarm dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_vld  (sample_vld),
        .sample_temp (sample_temp),
        .thresh_temp (thresh_temp),
        .cmp_mode    (cmp_mode),
        .alarm_ie    (alarm_ie),
        .alarm_clr   (alarm_clr),
        .ready_clr   (ready_clr),
        .cmp_live    (cmp_live),
        .alarm_flag  (alarm_flag),
        .data_ready  (data_ready),
        .alarm_irq   (alarm_irq)
    );

    // {mode, threshold, sample, expected match}
    localparam int NVEC = 12;
    localparam logic [34:0] VEC [NVEC] = '{
        {2'd0, 16'h0640, 16'h0600, 1'b1},  // R2 below
        {2'd0, 16'h0640, 16'h0640, 1'b1},  // R2 equal
        {2'd0, 16'h0640, 16'h0641, 1'b0},  // R2 above
        {2'd1, 16'h0640, 16'h0641, 1'b1},  // R3 above
        {2'd1, 16'h0640, 16'h0640, 1'b1},  // R3 equal
        {2'd1, 16'h0640, 16'h063F, 1'b0},  // R3 below
        {2'd1, 16'h0040, 16'hFFC0, 1'b0},  // R4 -1 vs +1
        {2'd0, 16'h0040, 16'hFFC0, 1'b1},  // R4
        {2'd1, 16'h8000, 16'h7FFF, 1'b1},  // R4 extremes
        {2'd0, 16'h8000, 16'h7FFF, 1'b0},  // R4
        {2'd2, 16'h0000, 16'h0000, 1'b0},  // R5 code 2
        {2'd3, 16'h7FFF, 16'h7FFF, 1'b0}   // R5 code 3
    };

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    // Strobe one sample; returns at the negedge after the capturing edge.
    task automatic send(input logic [15:0] s, input logic clr);
        sample_temp = s;
        sample_vld  = 1'b1;
        alarm_clr   = clr;
        @(negedge clk);
        sample_vld  = 1'b0;
        alarm_clr   = 1'b0;
    endtask

    task automatic pulse_clears();
        alarm_clr = 1'b1;
        ready_clr = 1'b1;
        @(negedge clk);
        alarm_clr = 1'b0;
        ready_clr = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "cmp_live", cmp_live, 1'b0);
        chk("R1", "alarm_flag", alarm_flag, 1'b0);
        chk("R1", "data_ready", data_ready, 1'b0);
        chk("R1", "alarm_irq", alarm_irq, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            pulse_clears();
            cmp_mode    = VEC[i][34:33];
            thresh_temp = VEC[i][32:17];
            send(VEC[i][16:1], 1'b0);
            chk($sformatf("R2-5 vec%0d", i), "cmp_live", cmp_live, VEC[i][0]);
            chk($sformatf("R2-5 vec%0d", i), "alarm_flag", alarm_flag, VEC[i][0]);
            chk("R11", "data_ready", data_ready, 1'b1);
        end

        // R6: no strobe, inputs change, live holds
        pulse_clears();
        cmp_mode = 2'd1; thresh_temp = 16'h0100;
        send(16'h0200, 1'b0);
        sample_temp = 16'h0000; thresh_temp = 16'h7000;
        repeat (2) @(negedge clk);
        chk("R6", "cmp_live hold", cmp_live, 1'b1);
        // R7: non-matching sample clears live but flag sticks
        thresh_temp = 16'h0100;
        send(16'h0010, 1'b0);
        chk("R6", "cmp_live update", cmp_live, 1'b0);
        chk("R7", "alarm_flag sticky", alarm_flag, 1'b1);

        // R10: gating by enable, same cycle
        alarm_ie = 1'b0; #1;
        chk("R10", "irq ie=0", alarm_irq, 1'b0);
        alarm_ie = 1'b1; #1;
        chk("R10", "irq ie=1", alarm_irq, 1'b1);

        // R8: clear, then stays clear with no new matching sample
        @(negedge clk);
        alarm_clr = 1'b1;
        @(negedge clk);
        alarm_clr = 1'b0;
        chk("R8", "flag cleared", alarm_flag, 1'b0);
        chk("R10", "irq after clear", alarm_irq, 1'b0);
        thresh_temp = 16'h0000;
        repeat (3) @(negedge clk);
        chk("R8", "flag stays clear", alarm_flag, 1'b0);

        // R9: set and clear in same cycle -> set wins
        thresh_temp = 16'h0100;
        send(16'h0300, 1'b1);
        chk("R9", "set beats clear", alarm_flag, 1'b1);

        // R11: ready clear, then clear+sample same cycle
        ready_clr = 1'b1;
        @(negedge clk);
        ready_clr = 1'b0;
        chk("R11", "ready cleared", data_ready, 1'b0);
        ready_clr = 1'b1;
        send(16'h0000, 1'b0);
        ready_clr = 1'b0;
        chk("R11", "ready set wins", data_ready, 1'b1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule